// File: doc/BRIEF.md
# 64-bit Integer Execution Unit with Overflow Traps

This block is the integer execution stage of a 64-bit load/store processor. Each cycle it can take one decoded operation, two 64-bit register operands and a 16-bit immediate. From these it computes a 64-bit result, a write-enable for the destination register and an overflow-trap flag. The outputs are registered and appear one clock later, qualified by a valid strobe.

The unit covers five groups of operations. The first is doubleword add-with-immediate. The second is word add and the third is word subtract; these two run on the low 32 bits and sign-extend the result to the full width. The fourth is signed and unsigned less-than compare. The fifth is the four bitwise logic functions. Each arithmetic operation comes in a trapping form and a wrapping form. Both forms produce the same result bits. Only the trapping form raises the trap on signed overflow, and when it does it blocks the register write.

Top module: `int_exec_unit`

## Requirements
- R1: Op codes 0 and 1 give rs plus the 16-bit immediate sign-extended to 64 bits, taken modulo 2^64.
- R2: Op code 0 raises the trap when that 64-bit signed addition overflows. Op code 1 never raises the trap.
- R3: Op codes 2 and 3 add rs[31:0] and rt[31:0]. Op codes 4 and 5 compute rs[31:0] minus rt[31:0]. In all four cases the 32-bit result is sign-extended into bits 63:32.
- R4: Op codes 2 and 4 raise the trap on signed 32-bit overflow. This includes subtracting the most negative word from a non-negative word. Op codes 3 and 5 never raise the trap.
- R5: Op code 6 returns 1 when rs is less than rt as two's-complement numbers, and 0 otherwise.
- R6: Op code 7 returns 1 when rs is less than rt as unsigned numbers, and 0 otherwise.
- R7: Op codes 8, 9, 10 and 11 return rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt), bit by bit over all 64 bits.
- R8: Whenever the trap is raised, the write-enable is low. For every other legal op it is high.
- R9: Op codes 12 to 15 return a zero result with the write-enable and the trap both low.
- R10: An op presented with in_valid high appears on the outputs after the next rising clock edge, with out_valid high. After a cycle in which in_valid is low, out_valid, out_wr_en and out_trap are low and out_result keeps its previous value.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Decoded operation code |
| rs_val | input | 64 | First source operand |
| rt_val | input | 64 | Second source operand |
| imm_val | input | 16 | Immediate field |
| out_valid | output | 1 | Registered outputs hold a fresh result |
| out_result | output | 64 | Result value |
| out_wr_en | output | 1 | Write the result to the destination register |
| out_trap | output | 1 | Signed overflow trap |

## Verification
The bench targets overflow at both the positive and the negative limit of each width. It includes the subtraction 0 minus the most negative word: a design that negates the subtrahend before checking signs misses that trap and writes a wrapped value. Paired trapping and wrapping vectors catch two faults: a wrap form that traps, and a trapping form that still asserts the write-enable. Word results with bit 31 set expose a missing sign extension. The compare of all-ones against 1 tells the signed compare from the unsigned one. Idle cycles after a trap expose a trap or write-enable that lingers, or a result that fails to hold.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int XLEN_D = 64;
  localparam int WLEN_D = 32;
  localparam int IMMW_D = 16;
  localparam int OPW    = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADDI64_TRAP = 4'd0,
    OP_ADDI64_WRAP = 4'd1,
    OP_ADD32_TRAP  = 4'd2,
    OP_ADD32_WRAP  = 4'd3,
    OP_SUB32_TRAP  = 4'd4,
    OP_SUB32_WRAP  = 4'd5,
    OP_LT_SIGNED   = 4'd6,
    OP_LT_UNSIGNED = 4'd7,
    OP_BIT_AND     = 4'd8,
    OP_BIT_OR      = 4'd9,
    OP_BIT_XOR     = 4'd10,
    OP_BIT_NOR     = 4'd11
  } alu_op_e;

  // Overflow of a signed add, judged from the operand and sum sign bits.
  function automatic logic add_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  // Overflow of a signed subtract a - b, judged from the original signs.
  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sd);
    return (sa != sb) && (sd != sa);
  endfunction

  function automatic logic op_legal(input alu_op_e op);
    return op <= OP_BIT_NOR;
  endfunction

  function automatic logic op_is_arith(input alu_op_e op);
    return op <= OP_SUB32_WRAP;
  endfunction

  function automatic logic op_is_logic(input alu_op_e op);
    return (op >= OP_BIT_AND) && (op <= OP_BIT_NOR);
  endfunction

  function automatic logic op_is_word(input alu_op_e op);
    return (op >= OP_ADD32_TRAP) && (op <= OP_SUB32_WRAP);
  endfunction

  function automatic logic op_traps(input alu_op_e op);
    return (op == OP_ADDI64_TRAP) || (op == OP_ADD32_TRAP) || (op == OP_SUB32_TRAP);
  endfunction

  function automatic logic bit_fn(input alu_op_e op, input logic a, input logic b);
    case (op)
      OP_BIT_AND: return a & b;
      OP_BIT_OR:  return a | b;
      OP_BIT_XOR: return a ^ b;
      OP_BIT_NOR: return ~(a | b);
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ialu_arith.sv
module ialu_arith
  import alu_pkg::*;
#(
  parameter int XLEN = XLEN_D,
  parameter int WLEN = WLEN_D,
  parameter int IMMW = IMMW_D
) (
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  rs,
  input  logic [WLEN-1:0]  rt_lo,
  input  logic [IMMW-1:0]  imm,
  output logic [XLEN-1:0]  arith_res,
  output logic             ovf_dw,
  output logic             ovf_word
);

  localparam int IMM_PAD  = XLEN - IMMW;
  localparam int WORD_PAD = XLEN - WLEN;

  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] dw_sum;
  logic [WLEN-1:0] rs_lo;
  logic [WLEN-1:0] w_sum;
  logic [WLEN-1:0] w_dif;
  logic [WLEN-1:0] w_pick;
  logic            ovf_wadd;
  logic            ovf_wsub;
  logic            is_sub;

  assign imm_x  = {{IMM_PAD{imm[IMMW-1]}}, imm};
  assign dw_sum = rs + imm_x;
  assign ovf_dw = add_ovf(rs[XLEN-1], imm_x[XLEN-1], dw_sum[XLEN-1]);

  assign rs_lo = rs[WLEN-1:0];
  assign w_sum = rs_lo + rt_lo;
  assign w_dif = rs_lo - rt_lo;

  assign ovf_wadd = add_ovf(rs_lo[WLEN-1], rt_lo[WLEN-1], w_sum[WLEN-1]);
  assign ovf_wsub = sub_ovf(rs_lo[WLEN-1], rt_lo[WLEN-1], w_dif[WLEN-1]);

  assign is_sub   = (op == OP_SUB32_TRAP) || (op == OP_SUB32_WRAP);
  assign w_pick   = is_sub ? w_dif : w_sum;
  assign ovf_word = is_sub ? ovf_wsub : ovf_wadd;

  always_comb begin
    if (op_is_word(op)) arith_res = {{WORD_PAD{w_pick[WLEN-1]}}, w_pick};
    else                arith_res = dw_sum;
  end

endmodule

// File: rtl/ialu_cmp.sv
module ialu_cmp #(
  parameter int XLEN = alu_pkg::XLEN_D
) (
  input  logic [XLEN-1:0] rs,
  input  logic [XLEN-1:0] rt,
  output logic            lt_s,
  output logic            lt_u
);

  logic sign_differs;

  // Unsigned compare is shared; the signed result only differs when signs differ.
  assign lt_u         = rs < rt;
  assign sign_differs = rs[XLEN-1] ^ rt[XLEN-1];
  assign lt_s         = sign_differs ? rs[XLEN-1] : lt_u;

endmodule

// File: rtl/ialu_logic.sv
module ialu_logic
  import alu_pkg::*;
#(
  parameter int XLEN = XLEN_D
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] rs,
  input  logic [XLEN-1:0] rt,
  output logic [XLEN-1:0] logic_res
);

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign logic_res[i] = bit_fn(op, rs[i], rt[i]);
  end

endmodule

// File: rtl/ialu_outreg.sv
module ialu_outreg #(
  parameter int XLEN = alu_pkg::XLEN_D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] res_d,
  input  logic            we_d,
  input  logic            trap_d,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_wr_en,
  output logic            out_trap
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
      out_trap   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res_d;
        out_wr_en  <= we_d;
        out_trap   <= trap_d;
      end else begin
        out_wr_en  <= 1'b0;
        out_trap   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import alu_pkg::*;
#(
  parameter int XLEN = XLEN_D,
  parameter int WLEN = WLEN_D,
  parameter int IMMW = IMMW_D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op_sel,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [IMMW-1:0] imm_val,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_wr_en,
  output logic            out_trap
);

  alu_op_e         op;
  logic [XLEN-1:0] arith_res;
  logic [XLEN-1:0] logic_res;
  logic            ovf_dw;
  logic            ovf_word;
  logic            lt_s;
  logic            lt_u;
  logic [XLEN-1:0] res_now;
  logic            trap_now;
  logic            we_now;
  logic            legal_now;

  assign op = alu_op_e'(op_sel);

  ialu_arith #(.XLEN(XLEN), .WLEN(WLEN), .IMMW(IMMW)) u_arith (
    .op       (op),
    .rs       (rs_val),
    .rt_lo    (rt_val[WLEN-1:0]),
    .imm      (imm_val),
    .arith_res(arith_res),
    .ovf_dw   (ovf_dw),
    .ovf_word (ovf_word)
  );

  ialu_cmp #(.XLEN(XLEN)) u_cmp (
    .rs  (rs_val),
    .rt  (rt_val),
    .lt_s(lt_s),
    .lt_u(lt_u)
  );

  ialu_logic #(.XLEN(XLEN)) u_logic (
    .op       (op),
    .rs       (rs_val),
    .rt       (rt_val),
    .logic_res(logic_res)
  );

  assign legal_now = op_legal(op);

  always_comb begin
    trap_now = 1'b0;
    if (op_traps(op)) trap_now = op_is_word(op) ? ovf_word : ovf_dw;
  end

  assign we_now = legal_now && !trap_now;

  always_comb begin
    if (op_is_arith(op))          res_now = arith_res;
    else if (op == OP_LT_SIGNED)  res_now = XLEN'(lt_s);
    else if (op == OP_LT_UNSIGNED) res_now = XLEN'(lt_u);
    else if (op_is_logic(op))     res_now = logic_res;
    else                          res_now = '0;
  end

  ialu_outreg #(.XLEN(XLEN)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .res_d     (res_now),
    .we_d      (we_now),
    .trap_d    (trap_now),
    .out_valid (out_valid),
    .out_result(out_result),
    .out_wr_en (out_wr_en),
    .out_trap  (out_trap)
  );

endmodule

// File: rtl/ialu_checker.sv
module ialu_checker #(
  parameter int XLEN = alu_pkg::XLEN_D,
  parameter int WLEN = alu_pkg::WLEN_D
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [3:0]      op_sel,
  input logic            trap_now,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_wr_en,
  input logic            out_trap
);

  AST_NO_WRITE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_trap |-> !out_wr_en);                                                   // R8

  AST_WRAP_NEVER_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op_sel == 4'd1 || op_sel == 4'd3 || op_sel == 4'd5) |=> !out_trap); // R4

  AST_TRAP_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_trap == $past(trap_now)) && out_valid);                   // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_wr_en && !out_trap && $stable(out_result)); // R10

  AST_COMPARE_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op_sel == 4'd6 || op_sel == 4'd7) |=> out_result[XLEN-1:1] == '0); // R5

  AST_WORD_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op_sel >= 4'd2 && op_sel <= 4'd5)
      |=> out_result[XLEN-1:WLEN] == {(XLEN-WLEN){out_result[WLEN-1]}});       // R3

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel >= 4'd12 |=> !out_wr_en && !out_trap && out_result == '0); // R9

endmodule

bind int_exec_unit ialu_checker #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .trap_now  (trap_now),
  .out_valid (out_valid),
  .out_result(out_result),
  .out_wr_en (out_wr_en),
  .out_trap  (out_trap)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [63:0] rs_val = '0;
  logic [63:0] rt_val = '0;
  logic [15:0] imm_val = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_wr_en;
  logic        out_trap;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .rs_val(rs_val), .rt_val(rt_val), .imm_val(imm_val),
    .out_valid(out_valid), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_trap(out_trap)
  );

  // {req, op, rs, rt, imm, result, trap, we}
  localparam int NV = 20;
  localparam logic [217:0] VEC [NV] = '{
    {4'd1,  4'd0,  64'h5, 64'h0, 16'hFFFF, 64'h4, 1'b0, 1'b1},                                  // R1
    {4'd2,  4'd0,  64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 16'h0001, 64'h8000_0000_0000_0000, 1'b1, 1'b0}, // R2
    {4'd2,  4'd1,  64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 16'h0001, 64'h8000_0000_0000_0000, 1'b0, 1'b1}, // R2
    {4'd2,  4'd0,  64'h8000_0000_0000_0000, 64'h0, 16'h8000, 64'h7FFF_FFFF_FFFF_8000, 1'b1, 1'b0}, // R2
    {4'd4,  4'd2,  64'h0000_0000_7FFF_FFFF, 64'h1, 16'h0, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0},   // R4
    {4'd3,  4'd3,  64'h0000_0000_7FFF_FFFF, 64'h1, 16'h0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b1},   // R3
    {4'd3,  4'd2,  64'hFFFF_FFFF_FFFF_FFFE, 64'h3, 16'h0, 64'h1, 1'b0, 1'b1},                     // R3
    {4'd4,  4'd4,  64'hFFFF_FFFF_8000_0000, 64'h1, 16'h0, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0},   // R4
    {4'd4,  4'd5,  64'hFFFF_FFFF_8000_0000, 64'h1, 16'h0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b1},   // R4
    {4'd3,  4'd4,  64'h3, 64'h5, 16'h0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1},                     // R3
    {4'd4,  4'd4,  64'h0, 64'hFFFF_FFFF_8000_0000, 16'h0, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0},   // R4
    {4'd5,  4'd6,  64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 64'h1, 1'b0, 1'b1},                     // R5
    {4'd6,  4'd7,  64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 64'h0, 1'b0, 1'b1},                     // R6
    {4'd5,  4'd6,  64'h5, 64'h5, 16'h0, 64'h0, 1'b0, 1'b1},                                       // R5
    {4'd6,  4'd7,  64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 64'h1, 1'b0, 1'b1},                     // R6
    {4'd7,  4'd8,  64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 16'h0, 64'hF000_F000_F000_F000, 1'b0, 1'b1}, // R7
    {4'd7,  4'd9,  64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 16'h0, 64'hFFF0_FFF0_FFF0_FFF0, 1'b0, 1'b1}, // R7
    {4'd7,  4'd10, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 16'h0, 64'h0FF0_0FF0_0FF0_0FF0, 1'b0, 1'b1}, // R7
    {4'd7,  4'd11, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 16'h0, 64'h000F_000F_000F_000F, 1'b0, 1'b1}, // R7
    {4'd9,  4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h1, 64'h0, 1'b0, 1'b0}                      // R9
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] im);
    @(negedge clk);
    op_sel = op; rs_val = a; rt_val = b; imm_val = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", 64'(out_valid), 64'h0);
    chk("R11 result", out_result, 64'h0);
    chk("R11 wr_en", 64'(out_wr_en), 64'h0);
    chk("R11 trap", 64'(out_trap), 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [217:0] v;
      string tag;
      v = VEC[i];
      issue(v[213:210], v[209:146], v[145:82], v[81:66]);
      tag = $sformatf("R%0d vec%0d", v[217:214], i);
      chk({tag, " result"}, out_result, v[65:2]);
      chk({tag, " trap"}, 64'(out_trap), 64'(v[1]));
      chk({tag, " wr_en R8"}, 64'(out_wr_en), 64'(v[0]));
      chk({tag, " valid R10"}, 64'(out_valid), 64'h1);
    end

    // R10: idle after a trapping op clears strobes, holds the result
    issue(4'd2, 64'h0000_0000_7FFF_FFFF, 64'h1, 16'h0);
    @(negedge clk);
    chk("R10 idle valid", 64'(out_valid), 64'h0);
    chk("R10 idle trap", 64'(out_trap), 64'h0);
    chk("R10 idle wr_en", 64'(out_wr_en), 64'h0);
    chk("R10 idle hold", out_result, 64'hFFFF_FFFF_8000_0000);

    // R10: back-to-back ops, each result one edge later
    @(negedge clk);
    op_sel = 4'd1; rs_val = 64'h10; imm_val = 16'hFFF0; in_valid = 1'b1;
    @(negedge clk);
    chk("R10 b2b first R1", out_result, 64'h0);
    op_sel = 4'd9; rs_val = 64'h0F; rt_val = 64'hF0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 b2b second R7", out_result, 64'hFF);
    chk("R10 b2b valid", 64'(out_valid), 64'h1);

    // R11: asynchronous reset mid-run
    issue(4'd7, 64'h1, 64'h2, 16'h0);
    #1 rst_n = 1'b0;
    #1;
    chk("R11 async result", out_result, 64'h0);
    chk("R11 async valid", 64'(out_valid), 64'h0);
    chk("R11 async wr_en", 64'(out_wr_en), 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule